// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block sets the number of bus-clock cycles that each memory access lasts, and it marks the end of each access. A requester presents an access with an address region, a chip-select index and a bus-mode flag. The controller picks the cycle length from those inputs and from its programmed wait settings. It counts out the cycles and raises `cycle_done` in the final one. External areas that run without a programmed wait may stretch the access with an active-low ready input.

The controller holds four small registers, reached through a write-only port:

- A protect register.
- Two mode registers. One holds the bus-clock float control and the other holds the global wait bit.
- A chip-select wait register.

The two mode registers accept writes only while the protect bit is set. The bus clock is brought out together with an output-enable, so that the pad cell can place the pin in high impedance.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, the protect, float, global-wait and all chip-select wait bits are 0, `cycle_done` is low and `bclk_oe` is high. An internal access therefore takes 1 cycle, and a separate-bus external access takes 2 cycles.
- R2: An access with `acc_region`=00 (special-function area) takes exactly 2 cycles, whatever the wait settings and `rdy_n` hold.
- R3: An access with `acc_region`=01 (internal memory) takes 1 cycle when the global wait bit is 0, and 2 cycles when it is 1. `rdy_n` has no effect on it.
- R4: An access with `acc_region[1]`=1 is external, with chip select `acc_cs`=n. On the separate bus (`acc_mux`=0) with the global wait bit 0, it takes 1 cycle when chip-select wait bit n (register bit 4+n) is 1, and 2 cycles when that bit is 0.
- R5: With the global wait bit 1, every separate-bus external access takes 2 cycles, whatever the chip-select wait bits hold.
- R6: Every multiplexed-bus external access (`acc_mux`=1) takes at least 3 cycles, and exactly 3 when ready does not extend it.
- R7: The register port selects a register with `reg_wr_sel`: 0 is protect (bit 1), 1 is mode A (bit 7 is float), 2 is mode B (bit 7 is global wait) and 3 is chip-select wait (bits 7:4). Writes to selects 1 and 2 are ignored while the protect bit is 0. The chip-select wait register is never protected. The protect bit keeps its value until software rewrites it.
- R8: `bclk_oe` is low exactly while the float bit is 1. `bclk_out` always carries the bus clock.
- R9: For an external access with the global wait bit 0 and its chip-select wait bit 0, `rdy_n` is sampled in every cycle from the last programmed cycle onward. The access ends in the first such cycle in which `rdy_n` is low. `rdy_n` is ignored for all other accesses.
- R10: `cycle_done` is a single-cycle pulse in the final cycle of each access. `acc_req` is accepted only while no access is in progress, so the earliest next request is the one presented in the cycle after `cycle_done`. A request raised during an access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 protect, 1 mode A, 2 mode B, 3 chip-select wait |
| reg_wr_data | input | DATA_W | Register write data |
| acc_req | input | 1 | Access request, sampled while idle |
| acc_region | input | 2 | 00 special-function area, 01 internal memory, 1x external |
| acc_cs | input | $clog2(NUM_CS) | Chip-select index for an external access |
| acc_mux | input | 1 | 1 selects the multiplexed bus for an external access |
| rdy_n | input | 1 | Active-low ready for wait-free external areas |
| cycle_done | output | 1 | High in the final cycle of an access |
| bclk_out | output | 1 | Bus clock toward the pad |
| bclk_oe | output | 1 | Pad drive enable; low places the pin in high impedance |

## Verification
The assertions check the following on every cycle:

- `cycle_done` never lasts two cycles and never appears while idle.
- Special-function accesses always end after two cycles.
- Multiplexed accesses never end before their third cycle.
- An unprotected write to either mode register leaves its bit unchanged.

Only the bench's scenarios can show the exact length for each combination of region, chip select, bus mode, global wait and chip-select wait pattern. The same holds for how far ready stretches an access, whether ready is ignored where it should be, and whether a request raised during an access is dropped.

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              acc_req,
  input  logic [1:0]        acc_region,
  input  logic [CSW-1:0]    acc_cs,
  input  logic              acc_mux,
  input  logic              rdy_n,
  output logic              cycle_done,
  output logic              bclk_out,
  output logic              bclk_oe
);
  localparam logic [1:0] SEL_PROT = 2'd0;
  localparam logic [1:0] SEL_MODEA = 2'd1;
  localparam logic [1:0] SEL_MODEB = 2'd2;
  localparam logic [1:0] SEL_CSW = 2'd3;
  localparam int PROT_BIT = 1;
  localparam int FLOAT_BIT = 7;
  localparam int WAIT_BIT = 7;
  localparam int CS_LSB = 4;

  logic              prot_q, float_q, wait_q;
  logic [NUM_CS-1:0] csw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= 1'b0;
      float_q <= 1'b0;
      wait_q  <= 1'b0;
      csw_q   <= '0;
    end else if (reg_wr_en) begin
      case (reg_wr_sel)
        SEL_PROT:  prot_q <= reg_wr_data[PROT_BIT];
        SEL_MODEA: if (prot_q) float_q <= reg_wr_data[FLOAT_BIT];
        SEL_MODEB: if (prot_q) wait_q <= reg_wr_data[WAIT_BIT];
        SEL_CSW:   csw_q <= reg_wr_data[CS_LSB +: NUM_CS];
        default: ;
      endcase
    end
  end

  logic unused_data;
  assign unused_data = ^{reg_wr_data[3:2], reg_wr_data[0]};

  logic       cs_fast, ext;
  logic [1:0] len_d;
  logic       rdy_en_d;

  assign ext      = acc_region[1];
  assign cs_fast  = csw_q[acc_cs];
  assign rdy_en_d = ext && !wait_q && !cs_fast;

  always_comb begin
    if (!ext)         len_d = acc_region[0] ? (wait_q ? 2'd2 : 2'd1) : 2'd2;
    else if (acc_mux) len_d = 2'd3;
    else if (wait_q)  len_d = 2'd2;
    else              len_d = cs_fast ? 2'd1 : 2'd2;
  end

  logic       active, rdy_en_q, at_len;
  logic [1:0] cnt, len_q;

  assign at_len     = (cnt == len_q);
  assign cycle_done = active && at_len && !(rdy_en_q && rdy_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= 2'd0;
      len_q    <= 2'd1;
      rdy_en_q <= 1'b0;
    end else if (!active) begin
      if (acc_req) begin
        active   <= 1'b1;
        cnt      <= 2'd1;
        len_q    <= len_d;
        rdy_en_q <= rdy_en_d;
      end
    end else if (cycle_done) begin
      active <= 1'b0;
    end else if (!at_len) begin
      cnt <= cnt + 2'd1;
    end
  end

  assign bclk_out = clk;
  assign bclk_oe  = !float_q;
endmodule

// File: rtl/bus_wait_ctrl_chk.sv
module bus_wait_ctrl_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic [1:0]        acc_region,
  input logic              acc_mux,
  input logic              cycle_done,
  input logic              active,
  input logic              reg_wr_en,
  input logic [1:0]        reg_wr_sel,
  input logic              prot_q,
  input logic              wait_q,
  input logic              float_q,
  input logic [NUM_CS-1:0] csw_q
);
  logic [2:0] c_cnt;
  logic [1:0] c_reg;
  logic       c_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_cnt <= 3'd0;
      c_reg <= 2'd0;
      c_mux <= 1'b0;
    end else begin
      if (!active && acc_req) begin
        c_reg <= acc_region;
        c_mux <= acc_mux;
      end
      c_cnt <= !active ? 3'd0 : (c_cnt == 3'd7 ? 3'd7 : c_cnt + 3'd1);
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !cycle_done);
  a_r2_sfr_two: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && c_reg == 2'b00) |-> c_cnt == 3'd1);
  a_r6_mux_min: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && c_reg[1] && c_mux) |-> c_cnt >= 3'd2);
  a_r7_modeb_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel == 2'd2 && !prot_q) |=> $stable(wait_q));
  a_r7_modea_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel == 2'd1 && !prot_q) |=> $stable(float_q));

  logic unused_csw;
  assign unused_csw = ^csw_q;
endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_region(acc_region),
  .acc_mux(acc_mux), .cycle_done(cycle_done), .active(active),
  .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .prot_q(prot_q),
  .wait_q(wait_q), .float_q(float_q), .csw_q(csw_q)
);

// File: tb/bus_wait_ctrl_tb.sv
`timescale 1ns/1ps
module bus_wait_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic       reg_wr_en = 0;
  logic [1:0] reg_wr_sel = 0;
  logic [7:0] reg_wr_data = 0;
  logic       acc_req = 0;
  logic [1:0] acc_region = 0;
  logic [1:0] acc_cs = 0;
  logic       acc_mux = 0;
  logic       rdy_n = 0;
  logic       cycle_done, bclk_out, bclk_oe;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  bus_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .acc_req(acc_req), .acc_region(acc_region),
    .acc_cs(acc_cs), .acc_mux(acc_mux), .rdy_n(rdy_n), .cycle_done(cycle_done),
    .bclk_out(bclk_out), .bclk_oe(bclk_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input [1:0] sel, input [7:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic run_acc(input [1:0] rg, input [1:0] cs, input mx, input int hold,
                         output int n);
    @(negedge clk);
    acc_req = 1; acc_region = rg; acc_cs = cs; acc_mux = mx; rdy_n = 1;
    @(negedge clk);
    acc_req = 0;
    n = 0;
    forever begin
      n++;
      rdy_n = (n <= hold);
      #1;
      if (cycle_done || n > 20) break;
      @(negedge clk);
    end
    rdy_n = 0;
  endtask

  function automatic int exp_len(input [1:0] rg, input [1:0] cs, input mx,
                                 input bit g, input [3:0] pat, input int hold);
    int b;
    bit hon;
    if (rg == 2'b00)      b = 2;
    else if (rg == 2'b01) b = g ? 2 : 1;
    else if (mx)          b = 3;
    else if (g)           b = 2;
    else                  b = pat[cs] ? 1 : 2;
    hon = rg[1] && !g && !pat[cs];
    if (hon && hold + 1 > b) b = hold + 1;
    return b;
  endfunction

  initial begin
    #1_000_000;
    failures++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done low after reset", cycle_done, 0);
    chk("R1 oe high after reset", bclk_oe, 1);
    chk("R8 bclk follows clock", bclk_out, clk);
    run_acc(2'b01, 0, 0, 0, n); chk("R1 internal after reset", n, 1);
    run_acc(2'b10, 0, 0, 0, n); chk("R1 cs0 separate after reset", n, 2);

    wr(2'd2, 8'h80);
    run_acc(2'b01, 0, 0, 0, n); chk("R7 unprotected mode B write ignored", n, 1);
    wr(2'd1, 8'h80);
    @(negedge clk); chk("R7 unprotected mode A write ignored", bclk_oe, 1);
    wr(2'd3, 8'h10);
    run_acc(2'b10, 0, 0, 0, n); chk("R7 cs wait register unprotected", n, 1);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h80);
    run_acc(2'b01, 0, 0, 0, n); chk("R3 protected global wait internal", n, 2);
    wr(2'd1, 8'h80);
    @(negedge clk); chk("R8 float sets oe low", bclk_oe, 0);
    wr(2'd1, 8'h00);
    @(negedge clk); chk("R7 protect persists oe high", bclk_oe, 1);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    run_acc(2'b01, 0, 0, 0, n); chk("R7 relocked write ignored", n, 2);
    wr(2'd0, 8'h02);

    for (int g = 0; g < 2; g++) begin
      wr(2'd2, g[0] ? 8'h80 : 8'h00);
      for (int p = 0; p < 16; p++) begin
        wr(2'd3, 8'(p << 4));
        for (int rg = 0; rg < 4; rg++)
          for (int cs = 0; cs < 4; cs++)
            for (int mx = 0; mx < 2; mx++) begin
              run_acc(2'(rg), 2'(cs), mx[0], 0, n);
              if (rg == 0) chk("R2 sfr length", n, exp_len(2'(rg), 2'(cs), mx[0], g[0], 4'(p), 0));
              else if (rg == 1) chk("R3 internal length", n, exp_len(2'(rg), 2'(cs), mx[0], g[0], 4'(p), 0));
              else if (mx == 1) chk("R6 mux length", n, exp_len(2'(rg), 2'(cs), mx[0], g[0], 4'(p), 0));
              else if (g == 1) chk("R5 global wait ext", n, exp_len(2'(rg), 2'(cs), mx[0], g[0], 4'(p), 0));
              else chk("R4 cs wait ext", n, exp_len(2'(rg), 2'(cs), mx[0], g[0], 4'(p), 0));
            end
      end
    end

    for (int g = 0; g < 2; g++) begin
      wr(2'd2, g[0] ? 8'h80 : 8'h00);
      for (int p = 0; p < 16; p += 5) begin
        wr(2'd3, 8'(p << 4));
        for (int rg = 0; rg < 4; rg++)
          for (int cs = 0; cs < 4; cs++)
            for (int mx = 0; mx < 2; mx++)
              for (int h = 1; h < 6; h++) begin
                run_acc(2'(rg), 2'(cs), mx[0], h, n);
                chk("R9 ready extension", n, exp_len(2'(rg), 2'(cs), mx[0], g[0], 4'(p), h));
              end
      end
    end

    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    @(negedge clk);
    acc_req = 1; acc_region = 2'b11; acc_cs = 1; acc_mux = 1;
    @(negedge clk);
    acc_req = 1;
    @(negedge clk);
    acc_req = 0;
    n = 2;
    while (!cycle_done && n < 20) begin @(negedge clk); n++; end
    chk("R10 first access length", n, 3);
    @(negedge clk);
    chk("R10 done single pulse", cycle_done, 0);
    begin
      int extra = 0;
      repeat (8) begin @(negedge clk); if (cycle_done) extra++; end
      chk("R10 request during access dropped", extra, 0);
    end
    run_acc(2'b01, 0, 0, 0, n); chk("R10 next access accepted", n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule